// File: doc/BRIEF.md
# Asynchronous Serial Receive Engine

This block turns a single asynchronous serial line into parallel bytes. The line rests high. A low level marks the start of a frame. The frame carries 7 or 8 data bits, least significant bit first, then an optional parity bit, then one stop bit. The engine runs on the system clock and paces itself from a tick that arrives sixteen times per bit period. Each bit is sampled once, near its centre.

A finished frame is placed in a holding register. The receive-full flag rises only when the frame arrived intact and the holding register was free. If the holding register was still full when the next frame ended, the overrun flag is set and the new frame is discarded. A parity mismatch or a low stop bit sets its own sticky flag. The frame's data is still written to the holding register, but the receive-full flag stays low. Software, or any consumer logic, pulses a read strobe to take the byte and free the holding register. Separate strobes clear each error flag. One enable bit gates both the receive-complete interrupt and the receive-error interrupt.

Top module: `uart_rx_core`

## Requirements
- R1: After reset the holding register reads 0x00, and the receive-full flag, all three error flags and both interrupts are 0.
- R2: The line passes through a two-stage synchronizer. A low level seen on a tick is re-checked 8 ticks later. If the line is high again by then, the event is a false start: it changes no output and does not disturb the next frame.
- R3: With the 8-bit setting, the first data bit on the line lands in bit 0 of the holding register and the eighth lands in bit 7.
- R4: With the 7-bit setting, seven data bits are received into bits 6..0 and bit 7 of the holding register reads 0.
- R5: With parity enabled, the parity bit follows the last data bit. Even parity makes the count of ones over the data bits and the parity bit even; odd parity makes it odd. With parity disabled, the stop bit directly follows the data and no parity check is made.
- R6: A frame with correct parity and a high stop bit, arriving while the receive-full flag is 0, is written to the holding register and sets the receive-full flag.
- R7: A parity mismatch sets the parity-error flag. The data is still written to the holding register and the receive-full flag stays 0.
- R8: A stop bit sampled low sets the framing-error flag. The data is still written to the holding register and the receive-full flag stays 0.
- R9: A frame that ends while the receive-full flag is 1 sets the overrun flag, leaves the holding register unchanged and leaves the receive-full flag at 1.
- R10: The read strobe clears the receive-full flag. A read made before the next frame ends lets that frame be received without overrun.
- R11: Each error flag stays set until its own clear strobe. A clear strobe affects no other flag.
- R12: The receive-complete interrupt equals the enable AND the receive-full flag. The receive-error interrupt equals the enable AND the OR of the three error flags. With the enable at 0, both interrupts stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line_i | input | 1 | Asynchronous serial input, idle high |
| baud_tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_8bit_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en_i | input | 1 | 1: a parity bit is expected |
| cfg_par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| cfg_irq_en_i | input | 1 | Enable for both interrupts |
| rd_strobe_i | input | 1 | Holding register read; clears receive-full |
| clr_ovr_i | input | 1 | Clears the overrun flag |
| clr_par_i | input | 1 | Clears the parity-error flag |
| clr_frm_i | input | 1 | Clears the framing-error flag |
| rx_data_o | output | 8 | Holding register |
| rx_full_o | output | 1 | Receive-full flag |
| ovr_err_o | output | 1 | Sticky overrun flag |
| par_err_o | output | 1 | Sticky parity-error flag |
| frm_err_o | output | 1 | Sticky framing-error flag |
| irq_done_o | output | 1 | Receive-complete interrupt |
| irq_err_o | output | 1 | Receive-error interrupt |

## Verification
The bench builds the block with its defaults: 16 ticks per bit, a two-stage synchronizer and an 8-bit holding register. It raises the tick every second clock, so one bit lasts 32 clocks. This keeps each frame short enough that every pairing of data width, parity mode and stop level fits in one run. Because the widths are at their defaults, the 7-bit case exercises the upper holding bit staying at zero. The short bit time also makes overrun and back-to-back reads cheap to reach, and the same holds for a false start a quarter of a bit long.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  // Widest character the engine accepts.
  localparam int unsigned RX_DATA_W = 8;

  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_PAR   = 3'd3,
    RX_STOP  = 3'd4
  } rx_state_e;

  typedef struct packed {
    logic [RX_DATA_W-1:0] data;
    logic                 par_bad;
    logic                 stop_bad;
  } rx_frame_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  // Reset to the idle (mark) level so no false start follows reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS    = 16,
  parameter int unsigned DATA_W = RX_DATA_W
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_i,
  input  logic      rxd_i,
  input  logic      cfg_8bit_i,
  input  logic      par_en_i,
  input  logic      par_odd_i,
  output logic      done_o,
  output rx_frame_t frame_o
);

  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_WIDE = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] IDX_NARROW = IDX_W'(DATA_W - 2);

  rx_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [DATA_W-1:0]  shreg_q, shreg_d;
  logic               parb_q, parb_d;
  logic               done_q, done_d;
  logic               par_bad_q, par_bad_d;
  logic               stop_bad_q, stop_bad_d;
  logic [IDX_W-1:0]   last_idx;
  logic               bit_mid;

  assign last_idx = cfg_8bit_i ? IDX_WIDE : IDX_NARROW;
  assign bit_mid  = (cnt_q == LAST_CNT);

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    idx_d      = idx_q;
    shreg_d    = shreg_q;
    parb_d     = parb_q;
    done_d     = 1'b0;
    par_bad_d  = par_bad_q;
    stop_bad_d = stop_bad_q;
    if (tick_i) begin
      unique case (state_q)
        RX_IDLE: begin
          if (!rxd_i) begin
            state_d = RX_START;
            cnt_d   = '0;
          end
        end
        RX_START: begin
          if (cnt_q == MID_CNT) begin
            if (!rxd_i) begin
              state_d = RX_DATA;
              cnt_d   = '0;
              idx_d   = '0;
              shreg_d = '0;
            end else begin
              state_d = RX_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_mid) begin
            shreg_d[idx_q] = rxd_i;
            cnt_d          = '0;
            if (idx_q == last_idx) begin
              idx_d   = '0;
              state_d = par_en_i ? RX_PAR : RX_STOP;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (bit_mid) begin
            parb_d  = rxd_i;
            cnt_d   = '0;
            state_d = RX_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (bit_mid) begin
            cnt_d      = '0;
            done_d     = 1'b1;
            stop_bad_d = !rxd_i;
            par_bad_d  = par_en_i & ((^shreg_q) ^ parb_q ^ par_odd_i);
            state_d    = RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RX_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      shreg_q    <= '0;
      parb_q     <= 1'b0;
      done_q     <= 1'b0;
      par_bad_q  <= 1'b0;
      stop_bad_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      idx_q      <= idx_d;
      shreg_q    <= shreg_d;
      parb_q     <= parb_d;
      done_q     <= done_d;
      par_bad_q  <= par_bad_d;
      stop_bad_q <= stop_bad_d;
    end
  end

  assign done_o           = done_q;
  assign frame_o.data     = shreg_q;
  assign frame_o.par_bad  = par_bad_q;
  assign frame_o.stop_bad = stop_bad_q;

  // R2
  false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && tick_i && cnt_q == MID_CNT && rxd_i) |=> (state_q == RX_IDLE));

  // R4
  narrow_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_DATA && !cfg_8bit_i) |-> (idx_q <= IDX_NARROW));

  // R5
  par_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_PAR) |-> par_en_i);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done_i,
  input  rx_frame_t            frame_i,
  input  logic                 rd_i,
  input  logic                 clr_ovr_i,
  input  logic                 clr_par_i,
  input  logic                 clr_frm_i,
  input  logic                 irq_en_i,
  output logic [RX_DATA_W-1:0] data_o,
  output logic                 full_o,
  output logic                 ovr_o,
  output logic                 par_o,
  output logic                 frm_o,
  output logic                 irq_done_o,
  output logic                 irq_err_o
);

  logic [RX_DATA_W-1:0] data_q, data_d;
  logic                 full_q, full_d;
  logic                 ovr_q, ovr_d;
  logic                 par_q, par_d;
  logic                 frm_q, frm_d;
  logic                 full_eff;

  // A read in the same cycle as a completion frees the register first.
  assign full_eff = full_q & ~rd_i;

  always_comb begin
    data_d = data_q;
    full_d = full_eff;
    ovr_d  = ovr_q & ~clr_ovr_i;
    par_d  = par_q & ~clr_par_i;
    frm_d  = frm_q & ~clr_frm_i;
    if (done_i) begin
      if (full_eff) begin
        ovr_d = 1'b1;
      end else begin
        data_d = frame_i.data;
        if (frame_i.par_bad) begin
          par_d = 1'b1;
        end
        if (frame_i.stop_bad) begin
          frm_d = 1'b1;
        end
        if (!frame_i.par_bad && !frame_i.stop_bad) begin
          full_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      par_q  <= 1'b0;
      frm_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
      par_q  <= par_d;
      frm_q  <= frm_d;
    end
  end

  assign data_o     = data_q;
  assign full_o     = full_q;
  assign ovr_o      = ovr_q;
  assign par_o      = par_q;
  assign frm_o      = frm_q;
  assign irq_done_o = irq_en_i & full_q;
  assign irq_err_o  = irq_en_i & (ovr_q | par_q | frm_q);

  // R6
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(done_i));

  // R7
  bad_frame_no_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !full_q && (frame_i.par_bad || frame_i.stop_bad)) |=> !full_q);

  // R9
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && full_q && !rd_i) |=> (full_q && ovr_q && $stable(data_q)));

  // R11
  par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_q && !clr_par_i) |=> par_q);

  // R11
  frm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_q && !clr_frm_i) |=> frm_q);

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_line_i,
  input  logic                 baud_tick_i,
  input  logic                 cfg_8bit_i,
  input  logic                 cfg_par_en_i,
  input  logic                 cfg_par_odd_i,
  input  logic                 cfg_irq_en_i,
  input  logic                 rd_strobe_i,
  input  logic                 clr_ovr_i,
  input  logic                 clr_par_i,
  input  logic                 clr_frm_i,
  output logic [RX_DATA_W-1:0] rx_data_o,
  output logic                 rx_full_o,
  output logic                 ovr_err_o,
  output logic                 par_err_o,
  output logic                 frm_err_o,
  output logic                 irq_done_o,
  output logic                 irq_err_o
);

  logic      rxd_sync;
  logic      frame_done;
  rx_frame_t frame;

  uart_rx_sync #(
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (rx_line_i),
    .sync_o  (rxd_sync)
  );

  uart_rx_framer #(
    .OVS    (OVS),
    .DATA_W (RX_DATA_W)
  ) framer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (baud_tick_i),
    .rxd_i      (rxd_sync),
    .cfg_8bit_i (cfg_8bit_i),
    .par_en_i   (cfg_par_en_i),
    .par_odd_i  (cfg_par_odd_i),
    .done_o     (frame_done),
    .frame_o    (frame)
  );

  uart_rx_status status_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (frame_done),
    .frame_i    (frame),
    .rd_i       (rd_strobe_i),
    .clr_ovr_i  (clr_ovr_i),
    .clr_par_i  (clr_par_i),
    .clr_frm_i  (clr_frm_i),
    .irq_en_i   (cfg_irq_en_i),
    .data_o     (rx_data_o),
    .full_o     (rx_full_o),
    .ovr_o      (ovr_err_o),
    .par_o      (par_err_o),
    .frm_o      (frm_err_o),
    .irq_done_o (irq_done_o),
    .irq_err_o  (irq_err_o)
  );

  // R12
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_irq_en_i) |-> (!irq_done_o && !irq_err_o));

endmodule

// File: tb/uart_rx_core_tb_top.sv
`timescale 1ns/1ps
module uart_rx_core_tb_top;

  localparam int TICK_DIV = 2;
  localparam int OVS      = 16;
  localparam int BIT_CLK  = OVS * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       tick = 1'b0;
  logic       cfg_8bit = 1'b1;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_irq_en = 1'b1;
  logic       rd = 1'b0;
  logic       clr_ovr = 1'b0;
  logic       clr_par = 1'b0;
  logic       clr_frm = 1'b0;
  logic [7:0] rx_data;
  logic       rx_full, ovr_err, par_err, frm_err, irq_done, irq_err;

  int n_cmp = 0;
  int n_bad = 0;
  int tick_cnt = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (tick_cnt == TICK_DIV - 1) begin
      tick_cnt <= 0;
      tick     <= 1'b1;
    end else begin
      tick_cnt <= tick_cnt + 1;
      tick     <= 1'b0;
    end
  end

  uart_rx_core dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_line_i     (rx_line),
    .baud_tick_i   (tick),
    .cfg_8bit_i    (cfg_8bit),
    .cfg_par_en_i  (cfg_par_en),
    .cfg_par_odd_i (cfg_par_odd),
    .cfg_irq_en_i  (cfg_irq_en),
    .rd_strobe_i   (rd),
    .clr_ovr_i     (clr_ovr),
    .clr_par_i     (clr_par),
    .clr_frm_i     (clr_frm),
    .rx_data_o     (rx_data),
    .rx_full_o     (rx_full),
    .ovr_err_o     (ovr_err),
    .par_err_o     (par_err),
    .frm_err_o     (frm_err),
    .irq_done_o    (irq_done),
    .irq_err_o     (irq_err)
  );

  typedef struct packed {
    logic [7:0] d;
    logic       b8;
    logic       pen;
    logic       odd;
    logic       badp;
    logic       stop;
    logic [7:0] xd;
    logic       xf;
    logic       xp;
    logic       xe;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b0},
    '{8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b0},
    '{8'h3D, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h3D, 1'b1, 1'b0, 1'b0},
    '{8'hF1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h71, 1'b1, 1'b0, 1'b0},
    '{8'h55, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h55, 1'b1, 1'b0, 1'b0},
    '{8'h96, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h96, 1'b0, 1'b1, 1'b0},
    '{8'h0F, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h0F, 1'b0, 1'b1, 1'b0},
    '{8'hC3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC3, 1'b0, 1'b0, 1'b1},
    '{8'h7E, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h7E, 1'b0, 1'b0, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rx_line = b;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic b8, input logic pen,
                            input logic odd, input logic badp, input logic stop);
    logic [7:0] dm;
    dm = b8 ? d : {1'b0, d[6:0]};
    @(negedge clk);
    send_bit(1'b0);
    for (int i = 0; i < (b8 ? 8 : 7); i++) send_bit(dm[i]);
    if (pen) send_bit((^dm) ^ odd ^ badp);
    send_bit(stop);
    rx_line = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk); rd = 1'b1; clr_ovr = 1'b1; clr_par = 1'b1; clr_frm = 1'b1;
    @(negedge clk); rd = 1'b0; clr_ovr = 1'b0; clr_par = 1'b0; clr_frm = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 data", rx_data, 8'h00);
    check("R1 full", rx_full, 0);
    check("R1 flags", {ovr_err, par_err, frm_err}, 0);
    check("R1 irqs", {irq_done, irq_err}, 0);

    // R2 false start: low for a quarter bit
    @(negedge clk);
    rx_line = 1'b0;
    repeat (BIT_CLK / 4) @(negedge clk);
    rx_line = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
    check("R2 false start full", rx_full, 0);
    check("R2 false start flags", {ovr_err, par_err, frm_err}, 0);
    check("R2 false start data", rx_data, 8'h00);

    // Table walk: R3 R4 R5 R6 R7 R8 R12
    for (int v = 0; v < NVEC; v++) begin
      cfg_8bit    = VECS[v].b8;
      cfg_par_en  = VECS[v].pen;
      cfg_par_odd = VECS[v].odd;
      send_frame(VECS[v].d, VECS[v].b8, VECS[v].pen, VECS[v].odd, VECS[v].badp, VECS[v].stop);
      check($sformatf("R3/R4 vec%0d data", v), rx_data, VECS[v].xd);
      check($sformatf("R6 vec%0d full", v), rx_full, VECS[v].xf);
      check($sformatf("R7/R5 vec%0d parity flag", v), par_err, VECS[v].xp);
      check($sformatf("R8 vec%0d framing flag", v), frm_err, VECS[v].xe);
      check($sformatf("R12 vec%0d irq_done", v), irq_done, VECS[v].xf);
      check($sformatf("R12 vec%0d irq_err", v), irq_err, VECS[v].xp | VECS[v].xe);
      clear_all();
    end

    // R9 overrun
    cfg_8bit = 1'b1; cfg_par_en = 1'b0;
    send_frame(8'h11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    send_frame(8'h22, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9 overrun flag", ovr_err, 1);
    check("R9 data kept", rx_data, 8'h11);
    check("R9 full kept", rx_full, 1);
    check("R9 R12 irq_err", irq_err, 1);

    // R11 clearing overrun leaves full
    @(negedge clk); clr_ovr = 1'b1;
    @(negedge clk); clr_ovr = 1'b0;
    @(negedge clk);
    check("R11 overrun cleared", ovr_err, 0);
    check("R11 full untouched", rx_full, 1);
    pulse_rd();
    check("R10 read clears full", rx_full, 0);

    // R10 back-to-back with read between
    send_frame(8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    pulse_rd();
    send_frame(8'hA6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R10 no overrun", ovr_err, 0);
    check("R10 new data", rx_data, 8'hA6);
    check("R10 full", rx_full, 1);
    clear_all();

    // R11 sticky parity flag vs other clears
    cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send_frame(8'h81, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R11 parity set", par_err, 1);
    @(negedge clk); clr_frm = 1'b1; clr_ovr = 1'b1; rd = 1'b1;
    @(negedge clk); clr_frm = 1'b0; clr_ovr = 1'b0; rd = 1'b0;
    repeat (BIT_CLK) @(negedge clk);
    check("R11 parity sticky", par_err, 1);
    @(negedge clk); clr_par = 1'b1;
    @(negedge clk); clr_par = 1'b0;
    @(negedge clk);
    check("R11 parity cleared", par_err, 0);

    // R12 interrupts gated off
    cfg_irq_en = 1'b0; cfg_par_en = 1'b0;
    send_frame(8'h42, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R12 full with irq off", rx_full, 1);
    check("R12 irq_done gated", irq_done, 0);
    send_frame(8'h43, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R12 overrun with irq off", ovr_err, 1);
    check("R12 irq_err gated", irq_err, 0);
    cfg_irq_en = 1'b1;
    @(negedge clk);
    check("R12 irq_err on enable", irq_err, 1);

    finish_run();
  end

endmodule